// File: doc/BRIEF.md
# Tagged Fully Associative Translation Cache

This block caches recent virtual-to-physical page translations for a processor pipeline. Every slot can hold any virtual page, and a lookup compares the requested virtual page number against all slots in the same cycle. A slot matches only when it is occupied and its page number is equal. Its address-space tag must also equal the current process ID, unless the slot is marked global. The answer comes back one cycle later on a valid/ready response stream. It reports a hit with the physical page number, a miss, a rights violation, or a page fault for a mapping that is marked not present.

The cache is managed from outside, by software or by a page-table walker, through three plain control inputs. Fill writes a translation. Targeted invalidate removes the translation for one page and process after a page-table change. Flush empties the whole cache, for example on a context switch when tags are not used.

A fill goes to a slot that already holds the same page for the same process if there is one. Otherwise it goes to the lowest-numbered empty slot, and when the cache is full it goes to the victim chosen by a binary-tree pseudo-LRU.

The request stream follows a back-pressure rule. A lookup is taken when `lk_valid` and `lk_ready` are both high. `lk_ready` is high whenever the response register is empty or is being drained in the same cycle. A pending response, with all its fields, is held unchanged for as long as `rsp_ready` stays low.

Top module: `xlate_tlb`

## Requirements
- R1: A lookup hits a slot that is occupied, has an equal virtual page number, and has either an equal process tag or the global bit set. A hit is reported as code 2'b00 together with that slot's physical page number.
- R2: A present mapping is checked against the rights field selected by `lk_user` (1 selects the user field, 0 the kernel field). Rights are encoded 2'b00 none, 2'b01 read, 2'b1x read and write. A read needs a non-zero field and a write needs bit 1 set. Failing the check gives code 2'b10.
- R3: A match on a slot whose present bit is 0 gives code 2'b11 (page fault), whatever the rights.
- R4: With no matching slot the code is 2'b01 (miss). Every non-hit response carries a physical page number of zero.
- R5: A slot filled with the global bit set matches a lookup of its page under any process ID.
- R6: A targeted invalidate removes every slot that matches its page and process ID under the R1 rule. A lookup issued in the following cycle or later sees the change, and other slots keep their contents.
- R7: A flush empties every slot in one cycle. A fill asserted in the same cycle as a flush is discarded.
- R8: A fill overwrites a slot already matching its page and process ID. Otherwise it takes the lowest-numbered empty slot, and when the cache is full it takes the pseudo-LRU victim.
- R9: The pseudo-LRU tree is touched by every lookup that matches a slot and by every fill, and the victim is never the slot touched last. After slots 0 to 15 are filled in order, the next two fills replace slot 0 and then slot 8.
- R10: Responses come one cycle after acceptance and reflect the contents before any update made in that same cycle. While `rsp_valid` is high and `rsp_ready` is low, `lk_ready` is low and the response fields do not change.
- R11: After reset no slot is occupied and `rsp_valid` is low, so the first lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be taken |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_pid | input | 8 | Current process ID |
| lk_write | input | 1 | Access is a write |
| lk_user | input | 1 | Access is made in user mode |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_code | output | 2 | 00 hit, 01 miss, 10 rights fault, 11 page fault |
| rsp_ppn | output | 20 | Physical page number on hit, else zero |
| fill_valid | input | 1 | Write a translation |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pid | input | 8 | Process tag to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_global | input | 1 | Install as a global mapping |
| fill_present | input | 1 | Mapping present (0 makes hits page-fault) |
| fill_kperm | input | 2 | Kernel rights |
| fill_uperm | input | 2 | User rights |
| inv_valid | input | 1 | Invalidate the translation below |
| inv_vpn | input | 20 | Page to invalidate |
| inv_pid | input | 8 | Process ID of the page to invalidate |
| flush | input | 1 | Empty the whole cache |

## Verification
A wrong comparator or occupancy bit shows up on the very next response as a miss where a hit was expected, or as a stale frame number. A corrupted pseudo-LRU tree stays hidden until the cache is full. It then shows up as the wrong page disappearing two fills later, which the bench exposes by looking up every resident page. A broken hold rule on the response register changes `rsp_code` or `rsp_ppn` within one stalled cycle.

// File: rtl/xtlb_pkg.sv
package xtlb_pkg;
  typedef enum logic [1:0] {
    RES_HIT    = 2'b00,
    RES_MISS   = 2'b01,
    RES_PROT   = 2'b10,
    RES_PFAULT = 2'b11
  } xlate_res_e;

  // Rights field: 00 none, 01 read, 1x read and write
  function automatic logic rights_ok(input logic [1:0] perm, input logic is_write);
    return is_write ? perm[1] : (perm != 2'b00);
  endfunction
endpackage

// File: rtl/xtlb_cam.sv
module xtlb_cam #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PID_W   = 8
) (
  input  logic [ENTRIES-1:0]             ent_valid,
  input  logic [ENTRIES-1:0]             ent_global,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
  input  logic [ENTRIES-1:0][PID_W-1:0]  ent_pid,
  input  logic [VPN_W-1:0]               key_vpn,
  input  logic [PID_W-1:0]               key_pid,
  output logic [ENTRIES-1:0]             hit_vec,
  output logic                           hit_any,
  output logic [$clog2(ENTRIES)-1:0]     hit_idx
);
  localparam int IDX_W = $clog2(ENTRIES);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = ent_valid[g] && (ent_vpn[g] == key_vpn) &&
                        (ent_global[g] || (ent_pid[g] == key_pid));
  end

  assign hit_any = |hit_vec;

  // lowest-numbered matching slot wins
  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) hit_idx = IDX_W'(i);
  end
endmodule

// File: rtl/xtlb_plru.sv
module xtlb_plru #(
  parameter int ENTRIES = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        touch_a_en,
  input  logic [$clog2(ENTRIES)-1:0]  touch_a_idx,
  input  logic                        touch_b_en,
  input  logic [$clog2(ENTRIES)-1:0]  touch_b_idx,
  output logic [$clog2(ENTRIES)-1:0]  victim
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int NODES = ENTRIES - 1;

  logic [NODES-1:0] tree_q, tree_d;

  // node bit 1 sends the victim walk right; a touch points it away
  function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] t,
                                             input logic [IDX_W-1:0] leaf);
    logic [NODES-1:0] r;
    int node;
    r = t;
    node = 0;
    for (int d = IDX_W - 1; d >= 0; d--) begin
      r[node] = ~leaf[d];
      node = 2 * node + 1 + (leaf[d] ? 1 : 0);
    end
    return r;
  endfunction

  always_comb begin
    tree_d = tree_q;
    if (touch_a_en) tree_d = touch(tree_d, touch_a_idx);
    if (touch_b_en) tree_d = touch(tree_d, touch_b_idx);
  end

  always_comb begin
    int node;
    node = 0;
    for (int d = 0; d < IDX_W; d++)
      node = 2 * node + 1 + (tree_q[node] ? 1 : 0);
    victim = IDX_W'(node - NODES);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tree_q <= '0;
    else        tree_q <= tree_d;
  end

  assert_victim_not_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_a_en || touch_b_en) |=> (victim != $past(touch_b_en ? touch_b_idx : touch_a_idx)))
    else $error("victim equals most recently touched slot");
endmodule

// File: rtl/xtlb_slot_pick.sv
module xtlb_slot_pick #(
  parameter int ENTRIES = 16
) (
  input  logic [ENTRIES-1:0]          ent_valid,
  input  logic                        dup_any,
  input  logic [$clog2(ENTRIES)-1:0]  dup_idx,
  input  logic [$clog2(ENTRIES)-1:0]  victim_idx,
  output logic [$clog2(ENTRIES)-1:0]  slot
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic                 have_free;
  logic [IDX_W-1:0]     free_idx;

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!ent_valid[i]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
  end

  always_comb begin
    if (dup_any)        slot = dup_idx;
    else if (have_free) slot = free_idx;
    else                slot = victim_idx;
  end
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int PID_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [PID_W-1:0]  lk_pid,
  input  logic              lk_write,
  input  logic              lk_user,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_code,
  output logic [PPN_W-1:0]  rsp_ppn,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PID_W-1:0]  fill_pid,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic              fill_global,
  input  logic              fill_present,
  input  logic [1:0]        fill_kperm,
  input  logic [1:0]        fill_uperm,
  input  logic              inv_valid,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic [PID_W-1:0]  inv_pid,
  input  logic              flush
);
  import xtlb_pkg::*;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             e_valid, e_global, e_present;
  logic [ENTRIES-1:0][VPN_W-1:0]  e_vpn;
  logic [ENTRIES-1:0][PID_W-1:0]  e_pid;
  logic [ENTRIES-1:0][PPN_W-1:0]  e_ppn;
  logic [ENTRIES-1:0][1:0]        e_kperm, e_uperm;

  logic [ENTRIES-1:0] lk_vec, fill_vec, inv_vec;
  logic               lk_any, fill_any, inv_any;
  logic [IDX_W-1:0]   lk_idx, fill_idx, inv_idx, victim, fill_slot;

  logic        lk_fire, fill_do;
  xlate_res_e  res_d;
  logic [1:0]  sel_perm;

  assign lk_ready = !rsp_valid || rsp_ready;
  assign lk_fire  = lk_valid && lk_ready;
  assign fill_do  = fill_valid && !flush;

  xtlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_cam_lk (
    .ent_valid(e_valid), .ent_global(e_global), .ent_vpn(e_vpn), .ent_pid(e_pid),
    .key_vpn(lk_vpn), .key_pid(lk_pid),
    .hit_vec(lk_vec), .hit_any(lk_any), .hit_idx(lk_idx));

  xtlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_cam_fill (
    .ent_valid(e_valid), .ent_global(e_global), .ent_vpn(e_vpn), .ent_pid(e_pid),
    .key_vpn(fill_vpn), .key_pid(fill_pid),
    .hit_vec(fill_vec), .hit_any(fill_any), .hit_idx(fill_idx));

  xtlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_cam_inv (
    .ent_valid(e_valid), .ent_global(e_global), .ent_vpn(e_vpn), .ent_pid(e_pid),
    .key_vpn(inv_vpn), .key_pid(inv_pid),
    .hit_vec(inv_vec), .hit_any(inv_any), .hit_idx(inv_idx));

  xtlb_plru #(.ENTRIES(ENTRIES)) u_plru (
    .clk(clk), .rst_n(rst_n),
    .touch_a_en(lk_fire && lk_any), .touch_a_idx(lk_idx),
    .touch_b_en(fill_do),           .touch_b_idx(fill_slot),
    .victim(victim));

  xtlb_slot_pick #(.ENTRIES(ENTRIES)) u_pick (
    .ent_valid(e_valid), .dup_any(fill_any), .dup_idx(fill_idx),
    .victim_idx(victim), .slot(fill_slot));

  // outcome of the lookup against the current contents
  always_comb begin
    sel_perm = lk_user ? e_uperm[lk_idx] : e_kperm[lk_idx];
    if (!lk_any)                         res_d = RES_MISS;
    else if (!e_present[lk_idx])         res_d = RES_PFAULT;
    else if (!rights_ok(sel_perm, lk_write)) res_d = RES_PROT;
    else                                 res_d = RES_HIT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RES_MISS;
      rsp_ppn   <= '0;
    end else if (lk_fire) begin
      rsp_valid <= 1'b1;
      rsp_code  <= res_d;
      rsp_ppn   <= (res_d == RES_HIT) ? e_ppn[lk_idx] : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // slot contents: flush beats everything; a fill beats an invalidate on its slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_valid   <= '0;
      e_global  <= '0;
      e_present <= '0;
      e_vpn     <= '0;
      e_pid     <= '0;
      e_ppn     <= '0;
      e_kperm   <= '0;
      e_uperm   <= '0;
    end else if (flush) begin
      e_valid <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        if (inv_valid && inv_vec[i]) e_valid[i] <= 1'b0;
      if (fill_valid) begin
        e_valid[fill_slot]   <= 1'b1;
        e_global[fill_slot]  <= fill_global;
        e_present[fill_slot] <= fill_present;
        e_vpn[fill_slot]     <= fill_vpn;
        e_pid[fill_slot]     <= fill_pid;
        e_ppn[fill_slot]     <= fill_ppn;
        e_kperm[fill_slot]   <= fill_kperm;
        e_uperm[fill_slot]   <= fill_uperm;
      end
    end
  end

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (e_valid == '0))
    else $error("slots remain after flush");

  assert_nonhit_zero_ppn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != RES_HIT) |-> (rsp_ppn == '0))
    else $error("non-hit response carries a frame number");

  assert_hold_stalled_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code) && $stable(rsp_ppn)))
    else $error("stalled response changed");

  assert_inv_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_any && !fill_valid) |=> (e_valid[$past(inv_idx)] == 1'b0))
    else $error("invalidated slot still occupied");
endmodule

// File: tb/xlate_tlb_tb.sv
module xlate_tlb_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_write = 1'b0, lk_user = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic [7:0]  lk_pid = '0;
  logic        lk_ready, rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_code;
  logic [19:0] rsp_ppn;
  logic        fill_valid = 1'b0, fill_global = 1'b0, fill_present = 1'b0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic [7:0]  fill_pid = '0;
  logic [1:0]  fill_kperm = '0, fill_uperm = '0;
  logic        inv_valid = 1'b0, flush = 1'b0;
  logic [19:0] inv_vpn = '0;
  logic [7:0]  inv_pid = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xlate_tlb u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vpn(lk_vpn), .lk_pid(lk_pid),
    .lk_write(lk_write), .lk_user(lk_user),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code), .rsp_ppn(rsp_ppn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pid(fill_pid), .fill_ppn(fill_ppn),
    .fill_global(fill_global), .fill_present(fill_present),
    .fill_kperm(fill_kperm), .fill_uperm(fill_uperm),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn), .inv_pid(inv_pid), .flush(flush));

  localparam logic [1:0] C_HIT = 2'b00, C_MISS = 2'b01, C_PROT = 2'b10, C_PF = 2'b11;

  // {vpn, pid, write, user, expected code, expected ppn}
  localparam int NV = 10;
  localparam logic [51:0] VEC [NV] = '{
    {20'h00010, 8'd5, 1'b0, 1'b1, C_HIT,  20'h0AAAA},  // R1
    {20'h00010, 8'd5, 1'b1, 1'b1, C_PROT, 20'h00000},  // R2 user write on read-only
    {20'h00010, 8'd5, 1'b1, 1'b0, C_HIT,  20'h0AAAA},  // R2 kernel write
    {20'h00010, 8'd6, 1'b1, 1'b1, C_HIT,  20'h0DDDD},  // R1 other process
    {20'h00010, 8'd7, 1'b0, 1'b0, C_MISS, 20'h00000},  // R4 tag mismatch
    {20'h00020, 8'd9, 1'b0, 1'b0, C_HIT,  20'h0BBBB},  // R5 global
    {20'h00020, 8'd9, 1'b0, 1'b1, C_PROT, 20'h00000},  // R2 user none
    {20'h00030, 8'd5, 1'b0, 1'b0, C_PF,   20'h00000},  // R3
    {20'h00030, 8'd6, 1'b0, 1'b0, C_MISS, 20'h00000},  // R4
    {20'h00040, 8'd5, 1'b0, 1'b0, C_MISS, 20'h00000}   // R4
  };

  task automatic check(input string req, input logic [21:0] act, input logic [21:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [19:0] v, input logic [7:0] p, input logic [19:0] f,
                      input logic g, input logic pres, input logic [1:0] kp, input logic [1:0] up);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = v; fill_pid = p; fill_ppn = f;
    fill_global = g; fill_present = pres; fill_kperm = kp; fill_uperm = up;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic lookup(input string req, input logic [19:0] v, input logic [7:0] p,
                        input logic w, input logic u, input logic [1:0] ec, input logic [19:0] ep);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = v; lk_pid = p; lk_write = w; lk_user = u;
    @(negedge clk);
    lk_valid = 1'b0;
    check(req, {rsp_valid, rsp_code, rsp_ppn[18:0]}, {1'b1, ec, ep[18:0]});
    check(req, {2'b0, rsp_ppn}, {2'b0, ep});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check("R11 rsp_valid", {21'b0, rsp_valid}, 22'd0);
    check("R11 lk_ready",  {21'b0, lk_ready},  22'd1);
    lookup("R11 empty", 20'h00010, 8'd5, 1'b0, 1'b0, C_MISS, 20'h0);

    fill(20'h00010, 8'd5, 20'h0AAAA, 1'b0, 1'b1, 2'b10, 2'b01);
    fill(20'h00020, 8'd0, 20'h0BBBB, 1'b1, 1'b1, 2'b10, 2'b00);
    fill(20'h00030, 8'd5, 20'h0CCCC, 1'b0, 1'b0, 2'b10, 2'b10);
    fill(20'h00010, 8'd6, 20'h0DDDD, 1'b0, 1'b1, 2'b10, 2'b10);

    for (int i = 0; i < NV; i++)
      lookup("R1-table", VEC[i][51:32], VEC[i][31:24], VEC[i][23], VEC[i][22],
             VEC[i][21:20], VEC[i][19:0]);

    // R6 targeted invalidate
    @(negedge clk);
    inv_valid = 1'b1; inv_vpn = 20'h00010; inv_pid = 8'd5;
    @(negedge clk);
    inv_valid = 1'b0;
    lookup("R6 removed", 20'h00010, 8'd5, 1'b0, 1'b0, C_MISS, 20'h0);
    lookup("R6 kept",    20'h00010, 8'd6, 1'b0, 1'b0, C_HIT, 20'h0DDDD);

    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    lk_valid = 1'b1; lk_vpn = 20'h00010; lk_pid = 8'd6; lk_write = 1'b0; lk_user = 1'b0;
    @(negedge clk);
    lk_vpn = 20'h00020; lk_pid = 8'd9;
    check("R10 first rsp", {rsp_valid, rsp_code, rsp_ppn[18:0]}, {1'b1, C_HIT, 19'h0DDDD});
    check("R10 lk_ready low", {21'b0, lk_ready}, 22'd0);
    repeat (2) @(negedge clk);
    check("R10 held", {rsp_valid, rsp_code, rsp_ppn[18:0]}, {1'b1, C_HIT, 19'h0DDDD});
    rsp_ready = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    check("R10 next rsp", {rsp_valid, rsp_code, rsp_ppn[18:0]}, {1'b1, C_HIT, 19'h0BBBB});

    // R7 flush, and flush with a simultaneous fill
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    lookup("R7 flushed global", 20'h00020, 8'd9, 1'b0, 1'b0, C_MISS, 20'h0);
    @(negedge clk);
    flush = 1'b1; fill_valid = 1'b1; fill_vpn = 20'h00050; fill_pid = 8'd1;
    fill_ppn = 20'h0EEEE; fill_global = 1'b0; fill_present = 1'b1;
    fill_kperm = 2'b10; fill_uperm = 2'b10;
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    lookup("R7 fill dropped", 20'h00050, 8'd1, 1'b0, 1'b0, C_MISS, 20'h0);

    // R8 and R9 replacement order
    for (int i = 0; i < 16; i++)
      fill(20'h00100 + 20'(i), 8'd1, 20'h00200 + 20'(i), 1'b0, 1'b1, 2'b10, 2'b10);
    fill(20'h00300, 8'd1, 20'h00301, 1'b0, 1'b1, 2'b10, 2'b10);
    fill(20'h00400, 8'd1, 20'h00401, 1'b0, 1'b1, 2'b10, 2'b10);
    lookup("R9 slot0 evicted", 20'h00100, 8'd1, 1'b0, 1'b0, C_MISS, 20'h0);
    lookup("R9 slot8 evicted", 20'h00108, 8'd1, 1'b0, 1'b0, C_MISS, 20'h0);
    lookup("R8 new A", 20'h00300, 8'd1, 1'b0, 1'b0, C_HIT, 20'h00301);
    lookup("R8 new B", 20'h00400, 8'd1, 1'b0, 1'b0, C_HIT, 20'h00401);
    // R8 refill of a resident page overwrites in place
    fill(20'h00101, 8'd1, 20'h00555, 1'b0, 1'b1, 2'b10, 2'b10);
    lookup("R8 overwrite", 20'h00101, 8'd1, 1'b0, 1'b0, C_HIT, 20'h00555);
    for (int i = 2; i < 16; i++)
      if (i != 8)
        lookup("R8 resident", 20'h00100 + 20'(i), 8'd1, 1'b0, 1'b0, C_HIT, 20'h00200 + 20'(i));

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule